// File: doc/BRIEF.md
# Lockable Protected Memory Window Control

This block owns a single configuration byte and the steering decision for one fixed memory window, 128 KiB starting at address 0x30000. Software has to negotiate the feature before it can use it: it writes a query value, and the byte then reports that RAM backs the window. After that, software can set a lock.

Once the lock is set, every access that arrives from normal execution mode and falls in the window goes to a black hole. Reads from the black hole return all ones and writes to it are dropped. Accesses made in the privileged management mode still reach RAM. The lock holds until the next reset.

Each memory request carries an address, a mode flag, a direction and a size. For every valid request the block decides between RAM and the black hole, and it supplies the black-hole read data. The RAM is not part of this block. When the block is built with the feature parameter off, the byte is a plain read/write register and nothing is ever diverted.

Top module: `lockwin_top`

## Requirements
- R1: After reset `cfg_rd_data` reads 0x00, and a normal-mode access inside the window is routed to RAM.
- R2: While the byte reads 0x00, every written value except 0xFF is discarded, and the byte keeps reading 0x00. This includes 0x02, so the window cannot be locked without first negotiating.
- R3: Writing 0xFF while the byte reads 0x00 makes it read 0x01 (RAM-backed). From then on only bit 1 can be written, so a write with bit 1 clear leaves the byte at 0x01.
- R4: After negotiation, a write with bit 1 (value 0x02) set locks the window. The byte then reads exactly 0x02 and ignores every later write.
- R5: While locked, a normal-mode request inside the window sets `route_hole`. A read returns 0xFF in byte lanes 0 through `mem_size`, where `mem_size` 0..3 means 1..4 bytes, and 0x00 in the lanes above. A write is dropped.
- R6: While locked, a management-mode request inside the window is routed to RAM.
- R7: A reset clears the lock, the byte returns to 0x00, and normal-mode window accesses go to RAM again.
- R8: The window is decoded from the request's start address and covers 0x30000 to 0x4FFFF inclusive. Requests outside that range, and every request while the window is unlocked, are routed to RAM.
- R9: When `mem_req` is high, exactly one of `route_ram` and `route_hole` is high. When `mem_req` is low, both are low. `hole_rd_data` is zero unless a black-hole read is in progress.
- R10: With `FEATURE_EN` = 0 the byte reads back the last value written, and no request is ever diverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr_en | input | 1 | Write strobe for the configuration byte |
| cfg_wr_data | input | CFG_W | Value to write to the configuration byte |
| cfg_rd_data | output | CFG_W | Current value of the configuration byte |
| mem_req | input | 1 | Memory request valid |
| mem_addr | input | ADDR_W | Start address of the request |
| mem_priv | input | 1 | 1 = request made in the privileged management mode |
| mem_write | input | 1 | 1 = write, 0 = read |
| mem_size | input | clog2(DATA_W/8) | Access size in bytes minus one |
| route_ram | output | 1 | Send the request to RAM |
| route_hole | output | 1 | Send the request to the black hole |
| hole_rd_data | output | DATA_W | Read data returned by the black hole |

## Verification
The configuration byte is driven through three phases: a sweep of junk values before negotiation, writes with bit 1 clear and with bit 1 set after negotiation, and an assortment of values after the lock. Each phase separates a correct mask from one that opens too early, leaks the wrong bits, or lets the lock be undone. In the locked state, requests are taken from a table that crosses the window edges (0x2FFFF, 0x30000, 0x4FFFF, 0x50000) with both modes, both directions and all four sizes. This shows off-by-one decode errors, a mode flag that is ignored, and a lane mask that is wrong. A reset in the middle of the run and a second instance with the feature off confirm that the lock is released and that the plain-register variant never diverts.

// File: rtl/lockwin_pkg.sv
package lockwin_pkg;

  // Negotiation progress of the protected window
  typedef enum logic [1:0] {
    WS_IDLE   = 2'd0,
    WS_OPEN   = 2'd1,
    WS_LOCKED = 2'd2
  } win_state_e;

  localparam logic [7:0] QUERY_CODE  = 8'hFF;
  localparam logic [7:0] RAM_CODE    = 8'h01;
  localparam logic [7:0] LOCK_CODE   = 8'h02;
  localparam int unsigned LOCK_BIT   = 1;

endpackage

// File: rtl/lockwin_rst_sync.sv
module lockwin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/lockwin_cfg.sv
module lockwin_cfg
  import lockwin_pkg::*;
#(
  parameter int unsigned CFG_W      = 8,
  parameter bit          FEATURE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             locked
);

  if (FEATURE_EN) begin : g_guarded
    win_state_e state_q;
    win_state_e state_d;
    logic       state_en;

    // Next state: the effective write mask is 0xFF in IDLE, only the
    // lock bit in OPEN, and nothing in LOCKED.
    always_comb begin
      state_d  = state_q;
      state_en = wr_en;
      unique case (state_q)
        WS_IDLE: begin
          if (wr_data == CFG_W'(QUERY_CODE)) begin
            state_d = WS_OPEN;
          end
        end
        WS_OPEN: begin
          if (wr_data[LOCK_BIT]) begin
            state_d = WS_LOCKED;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        state_q <= WS_IDLE;
      end else if (state_en) begin
        state_q <= state_d;
      end
    end

    always_comb begin
      unique case (state_q)
        WS_OPEN:   rd_data = CFG_W'(RAM_CODE);
        WS_LOCKED: rd_data = CFG_W'(LOCK_CODE);
        default:   rd_data = '0;
      endcase
    end

    assign locked = (state_q == WS_LOCKED);

  end else begin : g_plain
    logic [CFG_W-1:0] byte_q;
    logic [CFG_W-1:0] byte_d;
    logic             byte_en;

    always_comb begin
      byte_en = wr_en;
      byte_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= byte_d;
      end
    end

    assign rd_data = byte_q;
    assign locked  = 1'b0;
  end

endmodule

// File: rtl/lockwin_decode.sv
module lockwin_decode #(
  parameter int unsigned          ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]    WIN_BASE  = 'h30000,
  parameter int unsigned          WIN_BYTES = 'h20000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);

  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ADDR_W'(WIN_BYTES) - ADDR_W'(1);

  always_comb begin
    in_win = (addr >= WIN_BASE) && (addr <= WIN_LAST);
  end

endmodule

// File: rtl/lockwin_route.sv
module lockwin_route #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                          req,
  input  logic                          priv,
  input  logic                          write,
  input  logic [$clog2(DATA_W/8)-1:0]   size,
  input  logic                          in_win,
  input  logic                          locked,
  output logic                          to_ram,
  output logic                          to_hole,
  output logic [DATA_W-1:0]             hole_data
);

  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned SIZE_W = $clog2(LANES);

  logic divert;
  logic hole_rd;

  always_comb begin
    divert  = locked && in_win && !priv;
    to_hole = req && divert;
    to_ram  = req && !divert;
    hole_rd = to_hole && !write;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [SIZE_W-1:0] LANE_IDX = SIZE_W'(g);
    assign hole_data[g*8 +: 8] = (hole_rd && (LANE_IDX <= size)) ? 8'hFF : 8'h00;
  end

endmodule

// File: rtl/lockwin_top.sv
module lockwin_top #(
  parameter int unsigned       ADDR_W      = 32,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       CFG_W       = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 'h30000,
  parameter int unsigned       WIN_BYTES   = 'h20000,
  parameter bit                FEATURE_EN  = 1'b1,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr_en,
  input  logic [CFG_W-1:0]            cfg_wr_data,
  output logic [CFG_W-1:0]            cfg_rd_data,
  input  logic                        mem_req,
  input  logic [ADDR_W-1:0]           mem_addr,
  input  logic                        mem_priv,
  input  logic                        mem_write,
  input  logic [$clog2(DATA_W/8)-1:0] mem_size,
  output logic                        route_ram,
  output logic                        route_hole,
  output logic [DATA_W-1:0]           hole_rd_data
);

  logic rst_sync_n;
  logic win_locked;
  logic addr_in_win;

  lockwin_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lockwin_cfg #(
    .CFG_W      (CFG_W),
    .FEATURE_EN (FEATURE_EN)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .locked  (win_locked)
  );

  lockwin_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .WIN_BYTES (WIN_BYTES)
  ) u_dec (
    .addr   (mem_addr),
    .in_win (addr_in_win)
  );

  lockwin_route #(
    .DATA_W (DATA_W)
  ) u_route (
    .req       (mem_req),
    .priv      (mem_priv),
    .write     (mem_write),
    .size      (mem_size),
    .in_win    (addr_in_win),
    .locked    (win_locked),
    .to_ram    (route_ram),
    .to_hole   (route_hole),
    .hole_data (hole_rd_data)
  );

endmodule

// File: rtl/lockwin_chk.sv
module lockwin_chk #(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       CFG_W      = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 'h30000,
  parameter int unsigned       WIN_BYTES  = 'h20000,
  parameter bit                FEATURE_EN = 1'b1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_wr_en,
  input logic [CFG_W-1:0]            cfg_wr_data,
  input logic [CFG_W-1:0]            cfg_rd_data,
  input logic                        mem_req,
  input logic [ADDR_W-1:0]           mem_addr,
  input logic                        mem_priv,
  input logic                        mem_write,
  input logic [$clog2(DATA_W/8)-1:0] mem_size,
  input logic                        route_ram,
  input logic                        route_hole,
  input logic [DATA_W-1:0]           hole_rd_data
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = WIN_BASE + ADDR_W'(WIN_BYTES) - ADDR_W'(1);

  logic outside;
  assign outside = (mem_addr < WIN_BASE) || (mem_addr > LAST_ADDR);

  // R9
  a_r9_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({route_ram, route_hole}) && (mem_req == (route_ram || route_hole)));

  // R9
  a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !(route_hole && !mem_write) |-> (hole_rd_data == '0));

  // R6
  a_r6_priv_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_priv) |-> route_ram);

  // R8
  a_r8_outside_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && outside) |-> route_ram);

  if (FEATURE_EN) begin : g_guarded_chk
    // R2
    a_r2_junk_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_data == '0 && cfg_wr_en && cfg_wr_data != CFG_W'(8'hFF)) |=> (cfg_rd_data == '0));

    // R4
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_data == CFG_W'(8'h02)) |=> (cfg_rd_data == CFG_W'(8'h02)));

    // R5
    a_r5_hole_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (route_hole && !mem_write) |-> (hole_rd_data[7:0] == 8'hFF));

    // R8
    a_r8_unlocked_ram: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && cfg_rd_data != CFG_W'(8'h02)) |-> route_ram);
  end else begin : g_plain_chk
    // R10
    a_r10_no_divert: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> route_ram);
  end

endmodule

bind lockwin_top lockwin_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .CFG_W      (CFG_W),
  .WIN_BASE   (WIN_BASE),
  .WIN_BYTES  (WIN_BYTES),
  .FEATURE_EN (FEATURE_EN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_wr_data  (cfg_wr_data),
  .cfg_rd_data  (cfg_rd_data),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_priv     (mem_priv),
  .mem_write    (mem_write),
  .mem_size     (mem_size),
  .route_ram    (route_ram),
  .route_hole   (route_hole),
  .hole_rd_data (hole_rd_data)
);

// File: tb/sim_lockwin_top.sv
module sim_lockwin_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 12;

  // {addr, priv, write, size, exp_ram, exp_hole, exp_data}
  localparam logic [69:0] VEC [NVEC] = '{
    {32'h0003_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0000_00FF},
    {32'h0004_FFFF, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 32'hFFFF_FFFF},
    {32'h0004_0000, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 32'h0000_FFFF},
    {32'h0003_FFFC, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 32'h00FF_FFFF},
    {32'h0002_FFFF, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h0000_0000},
    {32'h0005_0000, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 32'h0000_0000},
    {32'h0003_0000, 1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 32'h0000_0000},
    {32'h0004_5678, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 32'h0000_0000},
    {32'h0003_0000, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 32'h0000_0000},
    {32'h0000_0000, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 32'h0000_0000},
    {32'hFFFF_FFFF, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 32'h0000_0000},
    {32'h0004_FFFF, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en0 = 1'b0, wr_en1 = 1'b0;
  logic [7:0]  wr_data0 = '0, wr_data1 = '0;
  logic [7:0]  rd0, rd1;
  logic        req = 1'b0, priv = 1'b0, wr = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic        ram0, hole0, ram1, hole1;
  logic [31:0] hdata0, hdata1;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockwin_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en0), .cfg_wr_data(wr_data0),
    .cfg_rd_data(rd0), .mem_req(req), .mem_addr(addr), .mem_priv(priv),
    .mem_write(wr), .mem_size(size), .route_ram(ram0), .route_hole(hole0),
    .hole_rd_data(hdata0)
  );

  lockwin_top #(.FEATURE_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en1), .cfg_wr_data(wr_data1),
    .cfg_rd_data(rd1), .mem_req(req), .mem_addr(addr), .mem_priv(priv),
    .mem_write(wr), .mem_size(size), .route_ram(ram1), .route_hole(hole1),
    .hole_rd_data(hdata1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write0(input logic [7:0] v);
    @(negedge clk);
    wr_en0 = 1'b1; wr_data0 = v;
    @(negedge clk);
    wr_en0 = 1'b0;
  endtask

  task automatic write1(input logic [7:0] v);
    @(negedge clk);
    wr_en1 = 1'b1; wr_data1 = v;
    @(negedge clk);
    wr_en1 = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic p, input logic w, input logic [1:0] s);
    @(negedge clk);
    req = 1'b1; addr = a; priv = p; wr = w; size = s;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset value", 32'(rd0), 32'h00);
    probe(32'h0003_1000, 1'b0, 1'b0, 2'd3);
    chk("R1 window to ram", {30'd0, ram0, hole0}, 32'h2);
    req = 1'b0;

    // R2 junk before negotiation, including the lock value
    for (int v = 0; v < 255; v += 17) begin
      write0(8'(v));
      chk("R2 junk discarded", 32'(rd0), 32'h00);
    end
    write0(8'h02);
    chk("R2 lock without query", 32'(rd0), 32'h00);
    write0(8'hFE);
    chk("R2 near query", 32'(rd0), 32'h00);

    // R3 negotiation
    write0(8'hFF);
    chk("R3 negotiated", 32'(rd0), 32'h01);
    write0(8'h01);
    chk("R3 bit1 clear 01", 32'(rd0), 32'h01);
    write0(8'hFD);
    chk("R3 bit1 clear FD", 32'(rd0), 32'h01);
    probe(32'h0003_0000, 1'b0, 1'b0, 2'd0);
    chk("R8 unlocked window to ram", {30'd0, ram0, hole0}, 32'h2);
    chk("R9 no hole data unlocked", hdata0, 32'h0);
    req = 1'b0;

    // R4 lock and stickiness
    write0(8'h02);
    chk("R4 locked", 32'(rd0), 32'h02);
    write0(8'h00);
    chk("R4 ignore 00", 32'(rd0), 32'h02);
    write0(8'hFF);
    chk("R4 ignore FF", 32'(rd0), 32'h02);
    write0(8'h01);
    chk("R4 ignore 01", 32'(rd0), 32'h02);

    // R5 R6 R8 R9 locked routing table
    for (int i = 0; i < NVEC; i++) begin
      probe(VEC[i][69:38], VEC[i][37], VEC[i][36], VEC[i][35:34]);
      chk($sformatf("R5/R6/R8 route vec %0d", i), {30'd0, ram0, hole0}, {30'd0, VEC[i][33:32]});
      chk($sformatf("R5/R9 data vec %0d", i), hdata0, VEC[i][31:0]);
    end

    // R9 idle request
    @(negedge clk);
    req = 1'b0; addr = 32'h0003_0000; priv = 1'b0; wr = 1'b0;
    #1;
    chk("R9 idle no route", {30'd0, ram0, hole0}, 32'h0);
    chk("R9 idle no data", hdata0, 32'h0);

    // R7 reset releases the lock
    do_reset();
    chk("R7 value after reset", 32'(rd0), 32'h00);
    probe(32'h0003_0000, 1'b0, 1'b0, 2'd3);
    chk("R7 window back to ram", {30'd0, ram0, hole0}, 32'h2);
    chk("R7 no hole data", hdata0, 32'h0);
    req = 1'b0;
    write0(8'h03);
    chk("R2 junk after reset", 32'(rd0), 32'h00);

    // R10 feature disabled instance
    write1(8'hA5);
    chk("R10 plain A5", 32'(rd1), 32'hA5);
    write1(8'hFF);
    chk("R10 plain FF", 32'(rd1), 32'hFF);
    write1(8'h02);
    chk("R10 plain 02", 32'(rd1), 32'h02);
    probe(32'h0003_0000, 1'b0, 1'b0, 2'd3);
    chk("R10 never diverted", {30'd0, ram1, hole1}, 32'h2);
    chk("R10 no hole data", hdata1, 32'h0);
    req = 1'b0;

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule